// File: doc/BRIEF.md
# Privilege Mode Nesting Tracker

This block holds the current privilege mode of a small 8-bit processor, either user or kernel, and feeds it to the address-mapping logic beside it. The processor raises a bus-status output while it reads an exception vector (reset, interrupt or software trap). The block takes the rising edge of that output as a trap entry. On each entry it saves the mode that was in force and switches to kernel mode. Just before the processor returns from an exception handler, software writes to a dedicated restore address. That write pops the saved mode back into force, so nested traps unwind in order.

The saved modes sit in a short last-in, first-out history, four entries by default. It is deep enough that a user program can make a system call, have that call interrupted, and still return to user mode once both handlers finish. A second dedicated address drops kernel software into user mode when it launches a program. The history has no other way to be seeded with a user entry, so this address is needed. The design follows a 14.75 MHz processor clock and has one register level between its inputs and the mode output.

State machine: two states, `MODE_KERNEL` and `MODE_USER`. Four named events move between them: `EV_TRAP` (vector-fetch rising edge), `EV_RESTORE` (write to the restore address), `EV_DROP` (write to the drop-to-user address) and `EV_NONE`. `EV_TRAP` leads to `MODE_KERNEL` from either state. `EV_RESTORE` leads to the popped mode, or to `MODE_KERNEL` when the history is empty. `EV_DROP` leads to `MODE_USER` from either state. `EV_NONE` keeps the state.

Top module: `priv_mode_tracker`

## Requirements
- R1: After reset, `kernel_mode` is 1 and the history is empty, so a restore write issued at once leaves `kernel_mode` at 1.
- R2: At a clock edge where `bus_status` is 1 and was 0 at the previous edge, the current mode is pushed onto the history and `kernel_mode` reads 1 after that edge.
- R3: Holding `bus_status` at 1 for several cycles pushes only once. A single restore write afterwards brings back the mode that was in force before the fetch.
- R4: At an edge where `wr_strobe` and `restore_hit` are both 1 (and R10 does not apply), the newest history entry is removed and becomes the current mode. A `kernel_mode` of 1 means kernel and 0 means user.
- R5: A restore write with an empty history sets `kernel_mode` to 1 and leaves the history empty.
- R6: The history holds at most DEPTH (default 4) entries. A push onto a full history discards the oldest entry, so the fifth restore after five pushes yields kernel mode.
- R7: At an edge where `wr_strobe` and `drop_hit` are 1 and `restore_hit` is 0 (and R10 does not apply), `kernel_mode` becomes 0 and the history is unchanged.
- R8: `wr_strobe` without an address match, or a match without `wr_strobe`, changes neither the mode nor the history.
- R9: A user-mode trap followed by a nested interrupt ends in kernel mode after the first restore write and in user mode after the second.
- R10: When a `bus_status` rising edge and a restore or drop write fall on the same edge, only the push happens. The write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_status | input | 1 | High while the processor fetches an exception vector |
| wr_strobe | input | 1 | Processor write cycle qualifier |
| restore_hit | input | 1 | Address decoder hit on the restore-previous-mode location |
| drop_hit | input | 1 | Address decoder hit on the drop-to-user location |
| kernel_mode | output | 1 | 1 = kernel mode, 0 = user mode, registered |

## Verification
The assertions take for granted that `bus_status` is low while reset is asserted. Without that, the first edge after reset would count as a rise in the design, while `$past` would see a different value. They also take for granted that the address decoder never raises `restore_hit` and `drop_hit` together for one write. The stimulus keeps `bus_status` at 0 through reset and never asserts both hits in the same cycle. It drives each input only in the middle of a clock period, so every edge sees a single, settled event.

// File: rtl/priv_track_pkg.sv
package priv_track_pkg;

    // Privilege mode, also the FSM state encoding.
    typedef enum logic {
        MODE_USER   = 1'b0,
        MODE_KERNEL = 1'b1
    } mode_e;

    // One bus event per clock, already prioritised.
    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_TRAP    = 2'd1,
        EV_RESTORE = 2'd2,
        EV_DROP    = 2'd3
    } bus_event_e;

endpackage

// File: rtl/priv_event_decode.sv
module priv_event_decode
    import priv_track_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_status,
    input  logic       wr_strobe,
    input  logic       restore_hit,
    input  logic       drop_hit,
    output bus_event_e bus_event
);

    logic status_q;
    logic fetch_rise;
    logic restore_wr;
    logic drop_wr;

    // Previous value of the vector-fetch status, for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else begin
            status_q <= bus_status;
        end
    end

    always_comb begin
        fetch_rise = bus_status & ~status_q;
        restore_wr = wr_strobe & restore_hit;
        drop_wr    = wr_strobe & drop_hit & ~restore_hit;
    end

    // Trap entry outranks either write; restore outranks drop.
    always_comb begin
        if (fetch_rise) begin
            bus_event = EV_TRAP;
        end else if (restore_wr) begin
            bus_event = EV_RESTORE;
        end else if (drop_wr) begin
            bus_event = EV_DROP;
        end else begin
            bus_event = EV_NONE;
        end
    end

endmodule

// File: rtl/priv_mode_stack.sv
module priv_mode_stack
    import priv_track_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  mode_e            push_mode,
    output mode_e            top_mode,
    output logic [CNT_W-1:0] fill
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    mode_e            cell_q     [DEPTH];
    mode_e            from_above [DEPTH];
    mode_e            from_below [DEPTH];
    logic [CNT_W-1:0] fill_q;

    // Each cell loads its upper neighbour on push, its lower one on pop.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if (i == 0) begin : g_top
            assign from_above[i] = push_mode;
        end else begin : g_inner_up
            assign from_above[i] = cell_q[i-1];
        end

        if (i == DEPTH - 1) begin : g_bottom
            assign from_below[i] = MODE_KERNEL;
        end else begin : g_inner_dn
            assign from_below[i] = cell_q[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q[i] <= MODE_KERNEL;
            end else if (push) begin
                cell_q[i] <= from_above[i];
            end else if (pop) begin
                cell_q[i] <= from_below[i];
            end
        end
    end

    // Occupancy saturates at DEPTH; the bottom cell simply falls off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (push) begin
            if (fill_q != FULL_CNT) begin
                fill_q <= fill_q + 1'b1;
            end
        end else if (pop) begin
            if (fill_q != '0) begin
                fill_q <= fill_q - 1'b1;
            end
        end
    end

    // An empty history answers kernel.
    always_comb begin
        top_mode = (fill_q == '0) ? MODE_KERNEL : cell_q[0];
        fill     = fill_q;
    end

endmodule

// File: rtl/priv_mode_fsm.sv
module priv_mode_fsm
    import priv_track_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_event_e bus_event,
    input  mode_e      popped_mode,
    output mode_e      cur_mode,
    output logic       push,
    output logic       pop,
    output logic       kernel_mode
);

    mode_e state_q;
    mode_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_KERNEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_KERNEL: begin
                unique case (bus_event)
                    EV_TRAP:    state_d = MODE_KERNEL;
                    EV_RESTORE: state_d = popped_mode;
                    EV_DROP:    state_d = MODE_USER;
                    EV_NONE:    state_d = MODE_KERNEL;
                endcase
            end
            MODE_USER: begin
                unique case (bus_event)
                    EV_TRAP:    state_d = MODE_KERNEL;
                    EV_RESTORE: state_d = popped_mode;
                    EV_DROP:    state_d = MODE_USER;
                    EV_NONE:    state_d = MODE_USER;
                endcase
            end
        endcase
    end

    // Outputs.
    always_comb begin
        cur_mode    = state_q;
        push        = (bus_event == EV_TRAP);
        pop         = (bus_event == EV_RESTORE);
        kernel_mode = (state_q == MODE_KERNEL);
    end

endmodule

// File: rtl/priv_mode_tracker.sv
module priv_mode_tracker
    import priv_track_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_status,
    input  logic wr_strobe,
    input  logic restore_hit,
    input  logic drop_hit,
    output logic kernel_mode
);

    bus_event_e       bus_event;
    mode_e            cur_mode;
    mode_e            popped_mode;
    logic             push;
    logic             pop;
    logic [CNT_W-1:0] hist_cnt;

    priv_event_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_status  (bus_status),
        .wr_strobe   (wr_strobe),
        .restore_hit (restore_hit),
        .drop_hit    (drop_hit),
        .bus_event   (bus_event)
    );

    priv_mode_stack #(
        .DEPTH (DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_mode (cur_mode),
        .top_mode  (popped_mode),
        .fill      (hist_cnt)
    );

    priv_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_event   (bus_event),
        .popped_mode (popped_mode),
        .cur_mode    (cur_mode),
        .push        (push),
        .pop         (pop),
        .kernel_mode (kernel_mode)
    );

endmodule

// File: rtl/priv_mode_tracker_chk.sv
module priv_mode_tracker_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_status,
    input logic             wr_strobe,
    input logic             restore_hit,
    input logic             drop_hit,
    input logic             kernel_mode,
    input logic [CNT_W-1:0] hist_cnt
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (kernel_mode && hist_cnt == '0)); // R1

    AST_TRAP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_status && !$past(bus_status)) |=> kernel_mode); // R2

    AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_status && $past(bus_status) && !wr_strobe)
        |=> ($stable(kernel_mode) && $stable(hist_cnt))); // R3

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_status && !$past(bus_status)) && wr_strobe && restore_hit && hist_cnt == '0)
        |=> (kernel_mode && hist_cnt == '0)); // R5

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hist_cnt <= MAX_CNT); // R6

    AST_DROP_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_status && !$past(bus_status)) && wr_strobe && drop_hit && !restore_hit)
        |=> (!kernel_mode && $stable(hist_cnt))); // R7

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_status && !$past(bus_status)) && !wr_strobe)
        |=> ($stable(kernel_mode) && $stable(hist_cnt))); // R8

    AST_RISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_status && !$past(bus_status) && wr_strobe && restore_hit && hist_cnt < MAX_CNT)
        |=> (kernel_mode && hist_cnt == $past(hist_cnt) + 1'b1)); // R10

endmodule

bind priv_mode_tracker priv_mode_tracker_chk #(
    .DEPTH (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_status  (bus_status),
    .wr_strobe   (wr_strobe),
    .restore_hit (restore_hit),
    .drop_hit    (drop_hit),
    .kernel_mode (kernel_mode),
    .hist_cnt    (hist_cnt)
);

// File: tb/test_priv_mode_tracker.sv
module test_priv_mode_tracker;

    localparam int HIST = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_status = 1'b0;
    logic wr_strobe = 1'b0;
    logic restore_hit = 1'b0;
    logic drop_hit = 1'b0;
    logic kernel_mode;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference model: 1 = kernel.
    bit m_mode = 1'b1;
    bit m_prev = 1'b0;
    bit m_hist[$];

    always #4 clk = ~clk;

    priv_mode_tracker #(.DEPTH(HIST)) i_priv_mode_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_status  (bus_status),
        .wr_strobe   (wr_strobe),
        .restore_hit (restore_hit),
        .drop_hit    (drop_hit),
        .kernel_mode (kernel_mode)
    );

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s kernel_mode actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit bs, input bit wr, input bit rh, input bit dh);
        if (bs && !m_prev) begin
            m_hist.push_front(m_mode);
            if (m_hist.size() > HIST) begin
                void'(m_hist.pop_back());
            end
            m_mode = 1'b1;
        end else if (wr && rh) begin
            if (m_hist.size() == 0) begin
                m_mode = 1'b1;
            end else begin
                m_mode = m_hist.pop_front();
            end
        end else if (wr && dh) begin
            m_mode = 1'b0;
        end
        m_prev = bs;
    endtask

    // One clock: drive mid-period, model at the edge, compare 2 ns later.
    task automatic cyc(input bit bs, input bit wr, input bit rh, input bit dh, input string tag);
        bus_status  = bs;
        wr_strobe   = wr;
        restore_hit = rh;
        drop_hit    = dh;
        @(posedge clk);
        model_edge(bs, wr, rh, dh);
        #2;
        check_bit(kernel_mode, m_mode, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic trap(input string tag);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, tag);
        idle(tag);
    endtask

    task automatic restore(input string tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, tag);
    endtask

    task automatic drop(input string tag);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, tag);
    endtask

    initial begin
        // Reset: bus_status held low throughout.
        repeat (3) @(posedge clk);
        #2;
        check_bit(kernel_mode, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        idle("R1");
        check_bit(kernel_mode, 1'b1, "R1 after reset");
        restore("R1 empty pop after reset");
        check_bit(kernel_mode, 1'b1, "R5 empty pop");

        // Drop to user, then non-matching accesses.
        drop("R7");
        check_bit(kernel_mode, 1'b0, "R7 drop to user");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R8 strobe only");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R8 restore match only");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, "R8 drop match only");
        check_bit(kernel_mode, 1'b0, "R8 still user");

        // Held vector fetch pushes once.
        cyc(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        check_bit(kernel_mode, 1'b1, "R2 trap enters kernel");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        idle("R3");
        restore("R4");
        check_bit(kernel_mode, 1'b0, "R3 one push, back to user");
        restore("R5");
        check_bit(kernel_mode, 1'b1, "R5 empty pop gives kernel");

        // Trap from user, nested interrupt, two restores.
        drop("R9");
        trap("R9 trap");
        trap("R9 nested interrupt");
        restore("R9");
        check_bit(kernel_mode, 1'b1, "R9 interrupt return stays kernel");
        restore("R9");
        check_bit(kernel_mode, 1'b0, "R9 trap return to user");

        // Overflow: pushes U,U,K,U,U; oldest U dropped.
        trap("R6");
        drop("R6");
        trap("R6");
        trap("R6");
        drop("R6");
        trap("R6");
        drop("R6");
        trap("R6");
        restore("R6");
        check_bit(kernel_mode, 1'b0, "R6 pop 1");
        restore("R6");
        check_bit(kernel_mode, 1'b0, "R6 pop 2");
        restore("R6");
        check_bit(kernel_mode, 1'b1, "R6 pop 3");
        restore("R6");
        check_bit(kernel_mode, 1'b0, "R6 pop 4");
        restore("R6");
        check_bit(kernel_mode, 1'b1, "R6 oldest discarded");

        // Simultaneous fetch rise with restore, then with drop.
        drop("R10");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, "R10 rise with restore");
        check_bit(kernel_mode, 1'b1, "R10 push wins");
        idle("R10");
        restore("R10");
        check_bit(kernel_mode, 1'b0, "R10 restore ignored, user saved");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, "R10 rise with drop");
        check_bit(kernel_mode, 1'b1, "R10 drop ignored");
        idle("R10");
        restore("R4");
        check_bit(kernel_mode, 1'b0, "R4 popped user");

        // Reset mid-run clears history.
        trap("R1");
        rst_n = 1'b0;
        @(posedge clk);
        m_mode = 1'b1;
        m_prev = 1'b0;
        m_hist.delete();
        #2;
        rst_n = 1'b1;
        restore("R1 history cleared");
        check_bit(kernel_mode, 1'b1, "R1 kernel after second reset");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule